// File: doc/BRIEF.md
# Sector Write Protection Gate

This block sits between the byte-load stream of a sector-programmed memory and the sequencer that runs the program cycle. Every load arrives as a one-cycle strobe with an address and a data byte. The gate watches the first loads of each load window for fixed command sequences. A three-load sequence turns protection on, or unlocks one program cycle while protection is already on. A six-load sequence turns protection off. Command loads are held back from the sequencer. All other loads pass through, registered, with their address and data unchanged.

The sequencer closes each load window with a one-cycle `win_close` pulse when its load timer runs out. At that point it samples `write_ok` to decide whether the program cycle writes the array or runs as a dummy busy period. A dummy cycle still takes the full busy time, because forwarded loads start it whether or not writing is permitted. The protection flag powers up from a parameter, off by default. Reset does not change it. Only the enable and disable sequences move it.

Top module: `wprot_gate`

## Requirements
- R1: After power-up with the default `PROT_INIT` = 0 and a reset, `fwd_valid` is 0, `prot_on` is 0 and `write_ok` is 1.
- R2: A load matches a command step only when its low 15 address bits and its data equal that step's pair. Address A is 5555h and address B is 2AAAh. The unlock/enable sequence is A/AAh, B/55h, A/A0h. The disable sequence is A/AAh, B/55h, A/80h, A/AAh, B/55h, A/20h.
- R3: Completing the three-load unlock/enable sequence sets `prot_on` to 1 and `write_ok` to 1 one cycle after the third load.
- R4: A load that matches the expected next command step is not forwarded. Every other load appears on `fwd_valid`/`fwd_addr`/`fwd_data` one cycle later, with its own address and data.
- R5: A load that does not match the expected step is forwarded as data. Command matching then stays off until the window closes, so later command-shaped loads in the same window are also forwarded.
- R6: While protection is on, a window with no unlock sequence forwards its data loads and keeps `write_ok` at 0.
- R7: While protection is on, a window that begins with the unlock sequence holds `write_ok` at 1 until the window closes.
- R8: One cycle after `win_close`, the unlock is dropped and matching restarts at the first step.
- R9: Completing the six-load disable sequence clears `prot_on` one cycle after the sixth load. Up to that load, `prot_on` keeps its value.
- R10: Asserting and releasing `rst_n` leaves `prot_on` unchanged.
- R11: The address bits above the low 15 take no part in command matching.
- R12: A partly matched command sequence that is cut by `win_close` has no effect. The next window must start the sequence again.
- R13: A load in the same cycle as `win_close` counts as the first load of the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It does not touch the protection flag |
| ld_valid | input | 1 | One-cycle byte-load strobe |
| ld_addr | input | ADDR_W | Load address |
| ld_data | input | DATA_W | Load data |
| win_close | input | 1 | Load window ended; the program cycle starts |
| fwd_valid | output | 1 | Forwarded load strobe toward the sequencer |
| fwd_addr | output | ADDR_W | Forwarded load address |
| fwd_data | output | DATA_W | Forwarded load data |
| write_ok | output | 1 | The coming program cycle may change the array |
| prot_on | output | 1 | Protection state |

## Verification
Every result of this block is due one clock edge after the load or `win_close` that causes it. This covers the forwarded strobe with its address and data, the protection flag, and the write permit. The bench drives each stimulus on a falling edge. It reads the outputs on the next falling edge, which falls just after the single register stage has taken the stimulus, and it does so before the next stimulus is applied. The first and second command steps are swept over all 256 data values, and the first step over every combination of upper address bits. The expected forward decision is computed from the requirement's key pairs, so the bench never reads internal state.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    // number of distinct address/data keys the decoder recognises
    localparam int NKEY = 5;

    // key indices into the decoder's hit vector
    localparam int K_LEAD1  = 0;   // address A, first lead code
    localparam int K_LEAD2  = 1;   // address B, second lead code
    localparam int K_GO     = 2;   // address A, unlock/enable code
    localparam int K_OFFSEQ = 3;   // address A, start of disable tail
    localparam int K_OFF    = 4;   // address A, final disable code

    // matcher position within the current load window
    typedef enum logic [2:0] {
        ST_W0  = 3'd0,   // expecting first lead
        ST_W1  = 3'd1,   // expecting second lead
        ST_W2  = 3'd2,   // expecting unlock or disable-tail code
        ST_D3  = 3'd3,   // disable tail: first lead again
        ST_D4  = 3'd4,   // disable tail: second lead again
        ST_D5  = 3'd5,   // disable tail: final code
        ST_OFF = 3'd6    // matching disarmed until window closes
    } seq_step_e;

    typedef struct packed {
        seq_step_e step;
        logic      unlock;
    } seq_state_t;

endpackage

// File: rtl/wprot_key_decode.sv
module wprot_key_decode
    import wprot_pkg::*;
#(
    parameter int                 DATA_W      = 8,
    parameter int                 CMD_AW      = 15,
    parameter logic [CMD_AW-1:0]  KEY_ADDR_A  = 15'h5555,
    parameter logic [CMD_AW-1:0]  KEY_ADDR_B  = 15'h2AAA,
    parameter logic [DATA_W-1:0]  LEAD1_CODE  = 8'hAA,
    parameter logic [DATA_W-1:0]  LEAD2_CODE  = 8'h55,
    parameter logic [DATA_W-1:0]  GO_CODE     = 8'hA0,
    parameter logic [DATA_W-1:0]  OFFSEQ_CODE = 8'h80,
    parameter logic [DATA_W-1:0]  OFF_CODE    = 8'h20
) (
    input  logic [CMD_AW-1:0] addr_lo,
    input  logic [DATA_W-1:0] data,
    output logic [NKEY-1:0]   key_hit
);

    localparam logic [CMD_AW-1:0] KADDR [NKEY] = '{
        KEY_ADDR_A, KEY_ADDR_B, KEY_ADDR_A, KEY_ADDR_A, KEY_ADDR_A
    };
    localparam logic [DATA_W-1:0] KDATA [NKEY] = '{
        LEAD1_CODE, LEAD2_CODE, GO_CODE, OFFSEQ_CODE, OFF_CODE
    };

    for (genvar k = 0; k < NKEY; k++) begin : g_key
        assign key_hit[k] = (addr_lo == KADDR[k]) && (data == KDATA[k]);
    end

endmodule

// File: rtl/wprot_seq.sv
module wprot_seq
    import wprot_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_valid,
    input  logic            win_close,
    input  logic [NKEY-1:0] key_hit,
    output logic            swallow,
    output logic            ev_enable,
    output logic            ev_disable,
    output logic            unlock_q
);

    seq_state_t cur_q;
    seq_state_t nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        swallow    = 1'b0;
        ev_enable  = 1'b0;
        ev_disable = 1'b0;

        // a closing window re-arms matching before this cycle's load is seen
        if (win_close) begin
            nxt_d.step   = ST_W0;
            nxt_d.unlock = 1'b0;
        end

        if (ld_valid) begin
            case (nxt_d.step)
                ST_W0: if (key_hit[K_LEAD1]) begin
                    nxt_d.step = ST_W1;
                    swallow    = 1'b1;
                end
                ST_W1: if (key_hit[K_LEAD2]) begin
                    nxt_d.step = ST_W2;
                    swallow    = 1'b1;
                end
                ST_W2: begin
                    if (key_hit[K_GO]) begin
                        nxt_d.step   = ST_OFF;
                        nxt_d.unlock = 1'b1;
                        ev_enable    = 1'b1;
                        swallow      = 1'b1;
                    end else if (key_hit[K_OFFSEQ]) begin
                        nxt_d.step = ST_D3;
                        swallow    = 1'b1;
                    end
                end
                ST_D3: if (key_hit[K_LEAD1]) begin
                    nxt_d.step = ST_D4;
                    swallow    = 1'b1;
                end
                ST_D4: if (key_hit[K_LEAD2]) begin
                    nxt_d.step = ST_D5;
                    swallow    = 1'b1;
                end
                ST_D5: if (key_hit[K_OFF]) begin
                    nxt_d.step = ST_OFF;
                    ev_disable = 1'b1;
                    swallow    = 1'b1;
                end
                default: ;
            endcase
            // any load that is not a command step disarms matching
            if (!swallow) begin
                nxt_d.step = ST_OFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.step   <= ST_W0;
            cur_q.unlock <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign unlock_q = cur_q.unlock;

    AST_UNLOCK_DROPS_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_close |=> !unlock_q); // R8
    AST_UNLOCK_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock_q) |-> $past(ld_valid)); // R3
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_enable && ev_disable)); // R9
    AST_EVENT_SWALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_enable || ev_disable) |-> (ld_valid && swallow)); // R4

endmodule

// File: rtl/wprot_flag.sv
module wprot_flag #(
    parameter bit PROT_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic prot_q
);

    logic prot_d;
    logic prot_r = PROT_INIT;

    // the flag holds its value through reset; it only moves on commands
    always_comb begin
        prot_d = prot_r;
        if (rst_n) begin
            if (set_i) begin
                prot_d = 1'b1;
            end else if (clr_i) begin
                prot_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        prot_r <= prot_d;
    end

    assign prot_q = prot_r;

    AST_PROT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_q) |-> $past(set_i)); // R3
    AST_PROT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_q) |-> $past(clr_i)); // R9

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
    import wprot_pkg::*;
#(
    parameter int                 ADDR_W      = 19,
    parameter int                 DATA_W      = 8,
    parameter int                 CMD_AW      = 15,
    parameter bit                 PROT_INIT   = 1'b0,
    parameter logic [CMD_AW-1:0]  KEY_ADDR_A  = 15'h5555,
    parameter logic [CMD_AW-1:0]  KEY_ADDR_B  = 15'h2AAA,
    parameter logic [DATA_W-1:0]  LEAD1_CODE  = 8'hAA,
    parameter logic [DATA_W-1:0]  LEAD2_CODE  = 8'h55,
    parameter logic [DATA_W-1:0]  GO_CODE     = 8'hA0,
    parameter logic [DATA_W-1:0]  OFFSEQ_CODE = 8'h80,
    parameter logic [DATA_W-1:0]  OFF_CODE    = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              win_close,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_data,
    output logic              write_ok,
    output logic              prot_on
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } fwd_t;

    logic [NKEY-1:0] key_hit;
    logic            swallow;
    logic            ev_enable;
    logic            ev_disable;
    logic            unlock_q;
    logic            prot_q;
    fwd_t            fwd_d;
    fwd_t            fwd_q;

    wprot_key_decode #(
        .DATA_W      (DATA_W),
        .CMD_AW      (CMD_AW),
        .KEY_ADDR_A  (KEY_ADDR_A),
        .KEY_ADDR_B  (KEY_ADDR_B),
        .LEAD1_CODE  (LEAD1_CODE),
        .LEAD2_CODE  (LEAD2_CODE),
        .GO_CODE     (GO_CODE),
        .OFFSEQ_CODE (OFFSEQ_CODE),
        .OFF_CODE    (OFF_CODE)
    ) u_dec (
        .addr_lo (ld_addr[CMD_AW-1:0]),
        .data    (ld_data),
        .key_hit (key_hit)
    );

    wprot_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid   (ld_valid),
        .win_close  (win_close),
        .key_hit    (key_hit),
        .swallow    (swallow),
        .ev_enable  (ev_enable),
        .ev_disable (ev_disable),
        .unlock_q   (unlock_q)
    );

    wprot_flag #(
        .PROT_INIT (PROT_INIT)
    ) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_enable),
        .clr_i  (ev_disable),
        .prot_q (prot_q)
    );

    always_comb begin
        fwd_d      = fwd_q;
        fwd_d.vld  = ld_valid && !swallow;
        if (ld_valid && !swallow) begin
            fwd_d.addr = ld_addr;
            fwd_d.data = ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_q <= '0;
        end else begin
            fwd_q <= fwd_d;
        end
    end

    assign fwd_valid = fwd_q.vld;
    assign fwd_addr  = fwd_q.addr;
    assign fwd_data  = fwd_q.data;
    assign write_ok  = unlock_q || !prot_q;
    assign prot_on   = prot_q;

    AST_FWD_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(ld_valid)); // R4
    AST_FWD_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_addr == $past(ld_addr) && fwd_data == $past(ld_data))); // R4
    AST_SWALLOWED_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && swallow) |=> !fwd_valid); // R4
    AST_PROT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && !write_ok) |=> (write_ok |-> $past(ld_valid) || !prot_on)); // R6

endmodule

// File: tb/wprot_gate_test.sv
module wprot_gate_test;

    localparam int AW = 19;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic          win_close = 1'b0;
    logic          fwd_valid;
    logic [AW-1:0] fwd_addr;
    logic [DW-1:0] fwd_data;
    logic          write_ok;
    logic          prot_on;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    wprot_gate uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .win_close (win_close),
        .fwd_valid (fwd_valid),
        .fwd_addr  (fwd_addr),
        .fwd_data  (fwd_data),
        .write_ok  (write_ok),
        .prot_on   (prot_on)
    );

    localparam logic [AW-1:0] A = 19'h05555;
    localparam logic [AW-1:0] B = 19'h02AAA;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // drive a load (optionally together with win_close) for one cycle
    // called at a falling edge; returns at the next falling edge
    task automatic drive(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic cl);
        ld_valid  = 1'b1;
        ld_addr   = a;
        ld_data   = d;
        win_close = cl;
        @(negedge clk);
        ld_valid  = 1'b0;
        win_close = 1'b0;
    endtask

    task automatic load_chk(input string req, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic exp_fwd);
        drive(a, d, 1'b0);
        check(req, {31'd0, fwd_valid}, {31'd0, exp_fwd});
        if (exp_fwd) begin
            check(req, {13'd0, fwd_addr}, {13'd0, a});
            check(req, {24'd0, fwd_data}, {24'd0, d});
        end
    endtask

    task automatic close_win;
        win_close = 1'b1;
        @(negedge clk);
        win_close = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 fwd_valid", {31'd0, fwd_valid}, 32'd0);
        check("R1 prot_on",   {31'd0, prot_on},   32'd0);
        check("R1 write_ok",  {31'd0, write_ok},  32'd1);

        // R2 R4: sweep first step data; only AAh at address A is held back
        for (int d = 0; d < 256; d++) begin
            close_win();
            load_chk("R2 first step", A, d[7:0], d != 8'hAA);
        end
        // R2 R4: sweep second step data after a matched first step
        for (int d = 0; d < 256; d++) begin
            close_win();
            load_chk("R2 lead", A, 8'hAA, 1'b0);
            load_chk("R2 second step", B, d[7:0], d != 8'h55);
        end
        // R11: upper address bits ignored in matching
        for (int u = 0; u < 16; u++) begin
            close_win();
            load_chk("R11 upper bits", {u[3:0], 15'h5555}, 8'hAA, 1'b0);
        end
        // R2: wrong low address bit is not a match
        close_win();
        load_chk("R2 addr miss", A ^ 19'h1, 8'hAA, 1'b1);

        // R4: plain data while unprotected
        close_win();
        load_chk("R4 data", 19'h00100, 8'h12, 1'b1);
        check("R4 write_ok unprot", {31'd0, write_ok}, 32'd1);

        // R3: enable sequence
        close_win();
        load_chk("R3 s1", A, 8'hAA, 1'b0);
        load_chk("R3 s2", B, 8'h55, 1'b0);
        check("R3 not yet", {31'd0, prot_on}, 32'd0);
        load_chk("R3 s3", A, 8'hA0, 1'b0);
        check("R3 prot_on", {31'd0, prot_on}, 32'd1);
        check("R3 write_ok", {31'd0, write_ok}, 32'd1);
        load_chk("R3 data after", 19'h00200, 8'h34, 1'b1);
        close_win();
        check("R8 unlock dropped", {31'd0, write_ok}, 32'd0);

        // R6 R5: protected, no unlock; command-shaped load after data is data
        load_chk("R6 data", 19'h00300, 8'h56, 1'b1);
        check("R6 write_ok", {31'd0, write_ok}, 32'd0);
        load_chk("R5 disarmed", A, 8'hAA, 1'b1);

        // R5: mismatch after a matched first step
        close_win();
        load_chk("R5 lead", A, 8'hAA, 1'b0);
        load_chk("R5 mismatch", B, 8'h56, 1'b1);
        load_chk("R5 later cmd", A, 8'hAA, 1'b1);
        check("R5 write_ok", {31'd0, write_ok}, 32'd0);

        // R12: prefix cut by window close
        close_win();
        load_chk("R12 s1", A, 8'hAA, 1'b0);
        load_chk("R12 s2", B, 8'h55, 1'b0);
        close_win();
        load_chk("R12 s3 alone", A, 8'hA0, 1'b1);
        check("R12 write_ok", {31'd0, write_ok}, 32'd0);

        // R10: reset does not clear protection
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 prot_on kept", {31'd0, prot_on},  32'd1);
        check("R10 write_ok",     {31'd0, write_ok}, 32'd0);

        // R7: unlock one window while protected
        close_win();
        load_chk("R7 s1", A, 8'hAA, 1'b0);
        load_chk("R7 s2", B, 8'h55, 1'b0);
        load_chk("R7 s3", A, 8'hA0, 1'b0);
        check("R7 write_ok", {31'd0, write_ok}, 32'd1);
        load_chk("R7 data", 19'h7FF00, 8'h9C, 1'b1);
        check("R7 held", {31'd0, write_ok}, 32'd1);
        close_win();
        check("R8 closed", {31'd0, write_ok}, 32'd0);

        // R13: load together with win_close begins the new window
        load_chk("R13 pre", 19'h00010, 8'h01, 1'b1);
        drive(A, 8'hAA, 1'b1);
        check("R13 swallowed", {31'd0, fwd_valid}, 32'd0);
        load_chk("R13 s2", B, 8'h55, 1'b0);
        load_chk("R13 s3", A, 8'hA0, 1'b0);
        check("R13 write_ok", {31'd0, write_ok}, 32'd1);

        // R9: disable sequence
        close_win();
        load_chk("R9 s1", A, 8'hAA, 1'b0);
        load_chk("R9 s2", B, 8'h55, 1'b0);
        load_chk("R9 s3", A, 8'h80, 1'b0);
        load_chk("R9 s4", A, 8'hAA, 1'b0);
        load_chk("R9 s5", B, 8'h55, 1'b0);
        check("R9 still on", {31'd0, prot_on}, 32'd1);
        load_chk("R9 s6", A, 8'h20, 1'b0);
        check("R9 prot off", {31'd0, prot_on},  32'd0);
        check("R9 write_ok", {31'd0, write_ok}, 32'd1);
        close_win();
        load_chk("R9 data after", 19'h00400, 8'h77, 1'b1);
        check("R9 write_ok after", {31'd0, write_ok}, 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule